// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Toggle-Bit Completion Polling

This block is a host-side master for a byte-wide parallel flash device. A single request names an operation (byte program, sector erase or whole-chip erase), a target address, a data byte and a poll budget. The block then writes the unlock-prefixed command cycles to the flash and watches the device's toggle status bit. From that it decides whether the operation finished, failed or ran out of budget.

The flash side is a simple synchronous port. A write lasts one cycle with address and data valid. A read is requested for one cycle, and the byte comes back in the following cycle. Completion is judged by comparing bit 6 of two back-to-back status reads. When the device raises its exceeded-limit flag (bit 5) while bit 6 still toggles, the block takes one more pair of reads before it declares failure. This catches the case where the operation finished between the two reads. On failure the block writes the read-array restore command by itself. One request runs at a time.

Top module: `flash_toggle_poll`

## Requirements
- R1: After synchronous reset: busy, done, mem_wr and mem_rd are low, and err_code is 00.
- R2: A program request (op_kind 00) writes exactly four cycles: AAh to 555h, 55h to 2AAh, A0h to 555h, then op_data to op_addr.
- R3: A sector erase request (op_kind 01) writes six cycles: AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 30h to op_addr.
- R4: A chip erase request (op_kind 10) writes the same first five cycles as R3, and its sixth cycle is 10h to 555h.
- R5: After the command cycles, every status read goes to op_addr. If bit 6 is equal in two consecutive reads, done pulses with err_code 00.
- R6: If bit 6 differs in a pair and bit 5 of the second read is 0, that pair counts against the poll budget and a new pair of reads follows.
- R7: If bit 6 differs in a pair and bit 5 of the second read is 1, exactly two more reads follow. If bit 6 is equal in those two, done pulses with err_code 00.
- R8: If bit 6 still differs in that recheck pair, the block writes F0h to op_addr in the next bus cycle, then pulses done with err_code 01.
- R9: When the number of counted pairs (R6) reaches poll_limit (a value of 0 acts as 1), done pulses with err_code 10 and no restore write is issued.
- R10: op_start is ignored while busy is high. A request with op_kind 11 is ignored and starts no bus activity.
- R11: done is high for exactly one cycle, and busy is low in that same cycle. No bus cycle occurs while idle, and mem_wr and mem_rd are never high together.
- R12: Each read is a one-cycle mem_rd pulse, and mem_rdata is sampled in the cycle that follows it. A request with k command cycles and n status reads therefore produces exactly k (+1 on failure) writes and n reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Request strobe, taken only when idle |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 ignored |
| op_addr | input | AW | Target byte or sector address |
| op_data | input | DW | Byte to program |
| poll_limit | input | CW | Maximum number of counted toggling pairs |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result of last request: 00 ok, 01 fail, 10 timeout |
| mem_wr | output | 1 | Flash write cycle |
| mem_rd | output | 1 | Flash read request |
| mem_addr | output | AW | Flash address |
| mem_wdata | output | DW | Flash write data |
| mem_rdata | input | DW | Flash read data, valid the cycle after mem_rd |

## Verification
The bench aims at the race in which bit 6 stops toggling just as bit 5 rises. A design that skipped the recheck would report failure there, and the read count and err_code expose that. A design that compared against the wrong read of the pair would misjudge settling by one pair, which shows up as a different number of status reads. Timeout is driven with poll_limit 0 and with small budgets to catch off-by-one pair counting. A request pulsed mid-run and an illegal op_kind must leave the write log untouched, or a design accepting them would show extra command cycles.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_FAIL = 2'd1,
    RES_TMO  = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RD,
    ST_RDW,
    ST_RST
  } st_e;

  localparam int STEP_W = 3;

  // number of command bus cycles for each operation kind
  function automatic logic [STEP_W-1:0] seq_len(op_kind_e k);
    return (k == OP_PROG) ? STEP_W'(4) : STEP_W'(6);
  endfunction

endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
  import fpc_pkg::*;
#(
  parameter int             AW       = 19,
  parameter int             DW       = 8,
  parameter logic [AW-1:0]  UNLOCK_A = AW'('h555),
  parameter logic [AW-1:0]  UNLOCK_B = AW'('h2AA)
) (
  input  logic [1:0]        kind,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [DW-1:0]     tgt_data,
  output logic [AW-1:0]     cyc_addr,
  output logic [DW-1:0]     cyc_data
);

  localparam logic [DW-1:0] KEY_HI   = DW'(8'hAA);
  localparam logic [DW-1:0] KEY_LO   = DW'(8'h55);
  localparam logic [DW-1:0] PGM_SET  = DW'(8'hA0);
  localparam logic [DW-1:0] ERA_SET  = DW'(8'h80);
  localparam logic [DW-1:0] ERA_SECT = DW'(8'h30);
  localparam logic [DW-1:0] ERA_CHIP = DW'(8'h10);

  logic is_prog;
  assign is_prog = (op_kind_e'(kind) == OP_PROG);

  always_comb begin
    cyc_addr = UNLOCK_A;
    cyc_data = KEY_HI;
    case (step)
      3'd0: begin cyc_addr = UNLOCK_A; cyc_data = KEY_HI; end
      3'd1: begin cyc_addr = UNLOCK_B; cyc_data = KEY_LO; end
      3'd2: begin cyc_addr = UNLOCK_A; cyc_data = is_prog ? PGM_SET : ERA_SET; end
      3'd3: begin
        cyc_addr = is_prog ? tgt_addr : UNLOCK_A;
        cyc_data = is_prog ? tgt_data : KEY_HI;
      end
      3'd4: begin cyc_addr = UNLOCK_B; cyc_data = KEY_LO; end
      3'd5: begin
        if (op_kind_e'(kind) == OP_SECT) begin
          cyc_addr = tgt_addr;
          cyc_data = ERA_SECT;
        end else begin
          cyc_addr = UNLOCK_A;
          cyc_data = ERA_CHIP;
        end
      end
      default: begin cyc_addr = UNLOCK_A; cyc_data = KEY_HI; end
    endcase
  end

endmodule

// File: rtl/fpc_toggle_judge.sv
module fpc_toggle_judge #(
  parameter int DW      = 8,
  parameter int TOG_BIT = 6,
  parameter int EXC_BIT = 5
) (
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  output logic          settled,
  output logic          exceeded
);

  // the pair is settled when the toggle bit no longer changes between reads
  assign settled  = (rd_a[TOG_BIT] == rd_b[TOG_BIT]);
  // exceeded-limit flag is taken from the later read of the pair
  assign exceeded = rd_b[EXC_BIT];

endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll
  import fpc_pkg::*;
#(
  parameter int            AW       = 19,
  parameter int            DW       = 8,
  parameter int            CW       = 16,
  parameter int            TOG_BIT  = 6,
  parameter int            EXC_BIT  = 5,
  parameter logic [AW-1:0] UNLOCK_A = AW'('h555),
  parameter logic [AW-1:0] UNLOCK_B = AW'('h2AA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic [CW-1:0] poll_limit,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam logic [DW-1:0] RESTORE_CMD = DW'(8'hF0);

  st_e               state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [1:0]        kind_q, kind_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [DW-1:0]     data_q, data_n;
  logic [DW-1:0]     first_q, first_n;
  logic [CW-1:0]     lim_q, lim_n;
  logic [CW:0]       cnt_q, cnt_n;
  logic [CW:0]       lim_eff;
  logic              rc_q, rc_n;
  logic              odd_q, odd_n;
  res_e              res_q, res_n;

  logic [AW-1:0]     tbl_addr;
  logic [DW-1:0]     tbl_data;
  logic              settled, exceeded;
  logic              finishing;

  assign lim_eff = (lim_q == '0) ? (CW+1)'(1) : {1'b0, lim_q};

  fpc_cmd_table #(
    .AW(AW), .DW(DW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_cmd (
    .kind     (kind_n),
    .step     (step_n),
    .tgt_addr (addr_n),
    .tgt_data (data_n),
    .cyc_addr (tbl_addr),
    .cyc_data (tbl_data)
  );

  fpc_toggle_judge #(
    .DW(DW), .TOG_BIT(TOG_BIT), .EXC_BIT(EXC_BIT)
  ) u_judge (
    .rd_a     (first_q),
    .rd_b     (mem_rdata),
    .settled  (settled),
    .exceeded (exceeded)
  );

  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    kind_n  = kind_q;
    addr_n  = addr_q;
    data_n  = data_q;
    first_n = first_q;
    lim_n   = lim_q;
    cnt_n   = cnt_q;
    rc_n    = rc_q;
    odd_n   = odd_q;
    res_n   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (op_start && (op_kind_e'(op_kind) != OP_NONE)) begin
          state_n = ST_CMD;
          kind_n  = op_kind;
          addr_n  = op_addr;
          data_n  = op_data;
          lim_n   = poll_limit;
          step_n  = '0;
          cnt_n   = '0;
          rc_n    = 1'b0;
          odd_n   = 1'b0;
          res_n   = RES_OK;
        end
      end
      ST_CMD: begin
        if (step_q == seq_len(op_kind_e'(kind_q)) - STEP_W'(1)) begin
          state_n = ST_RD;
          odd_n   = 1'b0;
        end else begin
          step_n = step_q + STEP_W'(1);
        end
      end
      ST_RD: state_n = ST_RDW;
      ST_RDW: begin
        if (!odd_q) begin
          first_n = mem_rdata;
          odd_n   = 1'b1;
          state_n = ST_RD;
        end else begin
          odd_n = 1'b0;
          if (settled) begin
            state_n = ST_IDLE;
            res_n   = RES_OK;
          end else if (rc_q) begin
            state_n = ST_RST;
          end else if (exceeded) begin
            rc_n    = 1'b1;
            state_n = ST_RD;
          end else begin
            cnt_n = cnt_q + (CW+1)'(1);
            if (cnt_q + (CW+1)'(1) >= lim_eff) begin
              state_n = ST_IDLE;
              res_n   = RES_TMO;
            end else begin
              state_n = ST_RD;
            end
          end
        end
      end
      ST_RST: begin
        state_n = ST_IDLE;
        res_n   = RES_FAIL;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign finishing = (state_q != ST_IDLE) && (state_n == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      kind_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      first_q   <= '0;
      lim_q     <= '0;
      cnt_q     <= '0;
      rc_q      <= 1'b0;
      odd_q     <= 1'b0;
      res_q     <= RES_OK;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_code  <= 2'b00;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q   <= state_n;
      step_q    <= step_n;
      kind_q    <= kind_n;
      addr_q    <= addr_n;
      data_q    <= data_n;
      first_q   <= first_n;
      lim_q     <= lim_n;
      cnt_q     <= cnt_n;
      rc_q      <= rc_n;
      odd_q     <= odd_n;
      res_q     <= res_n;
      busy      <= (state_n != ST_IDLE);
      done      <= finishing;
      if (finishing) err_code <= res_n;
      mem_wr    <= (state_n == ST_CMD) || (state_n == ST_RST);
      mem_rd    <= (state_n == ST_RD);
      mem_addr  <= (state_n == ST_CMD)  ? tbl_addr :
                   (state_n == ST_IDLE) ? '0 : addr_n;
      mem_wdata <= (state_n == ST_CMD) ? tbl_data :
                   (state_n == ST_RST) ? RESTORE_CMD : '0;
    end
  end

  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_wr || mem_rd));

  // R8
  fail_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == 2'b01) |-> ($past(mem_wr) && $past(mem_wdata) == RESTORE_CMD));

  // R9
  poll_budget_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= lim_eff));

endmodule

// File: tb/flash_toggle_poll_bench.sv
`timescale 1ns/1ps
module flash_toggle_poll_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [18:0] op_addr = '0;
  logic [7:0]  op_data = '0;
  logic [15:0] poll_limit = '0;
  logic        busy, done, mem_wr, mem_rd;
  logic [1:0]  err_code;
  logic [18:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #10 clk = ~clk;

  flash_toggle_poll u_flash_toggle_poll (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err_code(err_code),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // flash model state
  int          tn_m = 0;
  int          ea_m = 0;
  logic [18:0] tgt_m = '0;
  logic        clr = 1'b0;
  int          rcnt = 0;
  int          wcnt = 0;
  logic        rdbad = 1'b0;
  logic [18:0] wa [16];
  logic [7:0]  wd [16];

  function automatic logic [7:0] st_byte(int i, int tn, int ea);
    logic [7:0] v;
    if (i < tn) begin
      v = '0;
      v[6] = i[0];
      v[5] = (i >= ea);
      return v;
    end
    return 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      rcnt  <= 0;
      wcnt  <= 0;
      rdbad <= 1'b0;
    end else begin
      if (mem_rd) begin
        mem_rdata <= st_byte(rcnt, tn_m, ea_m);
        rcnt <= rcnt + 1;
        if (mem_addr != tgt_m) rdbad <= 1'b1;
      end
      if (mem_wr) begin
        if (wcnt < 16) begin
          wa[wcnt] <= mem_addr;
          wd[wcnt] <= mem_wdata;
        end
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_wr(logic [1:0] kind, int k, logic [18:0] a, logic [7:0] d);
    case (k)
      0: return {19'h555, 8'hAA};
      1: return {19'h2AA, 8'h55};
      2: return (kind == 2'd0) ? {19'h555, 8'hA0} : {19'h555, 8'h80};
      3: return (kind == 2'd0) ? {a, d} : {19'h555, 8'hAA};
      4: return {19'h2AA, 8'h55};
      5: return (kind == 2'd1) ? {a, 8'h30} : {19'h555, 8'h10};
      default: return {a, 8'hF0};
    endcase
  endfunction

  // expected outcome from the polling rules
  task automatic ref_outcome(input int tn, input int ea, input int lim,
                             output int reads, output logic [1:0] code);
    int i = 0;
    int pairs = 0;
    int le = (lim == 0) ? 1 : lim;
    logic [7:0] a, b, c, e;
    code = 2'd3;
    for (int g = 0; g < 100000; g++) begin
      a = st_byte(i, tn, ea);
      b = st_byte(i + 1, tn, ea);
      i += 2;
      if (a[6] == b[6]) begin code = 2'd0; break; end
      if (b[5]) begin
        c = st_byte(i, tn, ea);
        e = st_byte(i + 1, tn, ea);
        i += 2;
        code = (c[6] == e[6]) ? 2'd0 : 2'd1;
        break;
      end
      pairs++;
      if (pairs >= le) begin code = 2'd2; break; end
    end
    reads = i;
  endtask

  task automatic run_op(input logic [1:0] kind, input logic [18:0] a, input logic [7:0] d,
                        input int tn, input int ea, input int lim, input bit inject);
    int exp_reads;
    logic [1:0] exp_code;
    int nw;
    int mis;
    int w;
    int wsave;
    string rq;
    ref_outcome(tn, ea, lim, exp_reads, exp_code);
    nw = ((kind == 2'd0) ? 4 : 6) + ((exp_code == 2'd1) ? 1 : 0);
    @(negedge clk);
    tn_m = tn; ea_m = ea; tgt_m = a; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    op_kind = kind; op_addr = a; op_data = d; poll_limit = 16'(lim); op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accepted start", busy, 1);
    w = 0;
    while (!done && w < 4000) begin
      @(negedge clk);
      w++;
      if (inject && w == 3) op_start = 1'b1;
      if (inject && w == 4) op_start = 1'b0;
    end
    chk(w < 4000, "R5 watchdog completion", w, 0);
    rq = (exp_code == 2'd0) ? "R5/R7 result" : (exp_code == 2'd1) ? "R8 result" : "R9 result";
    chk(err_code == exp_code, rq, err_code, exp_code);
    chk(busy == 1'b0, "R11 busy low with done", busy, 0);
    chk(rcnt == exp_reads, "R12/R6 status read count", rcnt, exp_reads);
    chk(!rdbad, "R5 status read address", rdbad, 0);
    chk(wcnt == nw, "R12 write count", wcnt, nw);
    mis = 0;
    for (int k = 0; k < nw && k < 16; k++)
      if ({wa[k], wd[k]} != exp_wr(kind, (k < ((kind == 2'd0) ? 4 : 6)) ? k : 9, a, d)) mis++;
    rq = (kind == 2'd0) ? "R2 program cycles" : (kind == 2'd1) ? "R3 sector cycles" : "R4 chip cycles";
    chk(mis == 0, rq, mis, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    if (inject) begin
      wsave = wcnt;
      repeat (20) @(negedge clk);
      chk(wcnt == wsave && !busy, "R10 start while busy ignored", wcnt, wsave);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !mem_wr && !mem_rd && err_code == 2'b00, "R1 reset state",
        {busy, done, mem_wr, mem_rd, err_code}, 0);

    // R2 R5: settled immediately
    run_op(2'd0, 19'h12345, 8'h5A, 0, 100, 10, 1'b0);
    // R3 R6: several toggling pairs then settle
    run_op(2'd1, 19'h30000, 8'h00, 7, 100, 20, 1'b0);
    // R4 R7: bit5 rises as toggling stops, recheck succeeds
    run_op(2'd2, 19'h00777, 8'h00, 6, 4, 20, 1'b0);
    // R8: recheck still toggling
    run_op(2'd0, 19'h4ABCD, 8'h81, 1000, 2, 20, 1'b0);
    // R9: limit 0 acts as one pair
    run_op(2'd1, 19'h10000, 8'h00, 1000, 1000, 0, 1'b0);
    // R9: limit 5
    run_op(2'd2, 19'h00001, 8'h00, 1000, 1000, 5, 1'b0);
    // R10: start pulsed while busy
    run_op(2'd1, 19'h20000, 8'h00, 20, 1000, 50, 1'b1);

    // R10: op_kind 11 ignored
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    op_kind = 2'd3; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && wcnt == 0 && rcnt == 0, "R10 illegal kind ignored", wcnt + rcnt, 0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      run_op(2'($urandom % 3), 19'($urandom), 8'($urandom),
             int'($urandom % 40), int'($urandom % 50), int'(1 + $urandom % 25), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule